// File: doc/BRIEF.md
# Single-to-Half Precision Float Converter

This block turns a 32-bit IEEE-754 single-precision word into a 16-bit half-precision word. It rounds to nearest, with ties going to even. An input word is accepted with a valid strobe. The converted word leaves the block from one register stage, one clock later, together with its own valid strobe.

The conversion covers the whole input domain:
- signed zeros, with single-precision denormals flushed to zero;
- infinities, and NaNs, which are always made quiet;
- magnitudes too large for the half format, which saturate to infinity;
- magnitudes below the half normal range, which become half subnormals;
- a rounding increment that overflows the 10-bit fraction, which raises the exponent and can give infinity.

Top module: `f32_to_f16_conv`

## Requirements
- R1: An input whose exponent field (bits 30:23) is 0 produces a result whose bits 14:0 are 0, whatever the fraction (bits 22:0) holds.
- R2: An input exponent field of 255 with a zero fraction produces bits 14:0 = 0x7C00 (half exponent field bits 14:10 all ones, fraction bits 9:0 zero).
- R3: An input exponent field of 255 with a non-zero fraction produces bits 14:0 = 0x7E00, a quiet NaN.
- R4: An input exponent field from 143 to 254 produces bits 14:0 = 0x7C00.
- R5: An input exponent field from 113 to 142 produces a half exponent field of (field − 112). The half fraction is input bits 22:13, incremented when bit 12 is 1 and either some bit of 11:0 is 1 or bit 13 is 1.
- R6: When the rounding increment of R5 or R7 overflows the 10-bit fraction, the fraction becomes 0 and the exponent field rises by one. An input of 65520.0 (0x477FF000) therefore gives 0x7C00.
- R7: An input exponent field from 1 to 112 produces exponent field 0 and a fraction equal to |x|·2^24 rounded to nearest-even. A result of 1024 in this path gives 0x0400.
- R8: out_vld equals in_vld of the previous clock. A synchronous active-high rst clears out_vld and out_f16 at the next edge.
- R9: Result bit 15 equals input bit 31 for every input.
- R10: While in_vld is low, out_f16 keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input word is valid this cycle |
| in_f32 | input | 32 | Single-precision input word |
| out_vld | output | 1 | Result valid, one cycle after in_vld |
| out_f16 | output | 16 | Half-precision result |

## Verification
Some outcomes are hard to reach with uniform random words:
- exact ties, where the 12 sticky bits are all zero and the guard bit is one;
- a fraction of all ones that carries into the next binade, or into infinity.

A uniform draw almost never lands on either. The stimulus therefore mixes four draw modes:
- a fully random word;
- an exponent near the half range;
- the same exponent range with the low fraction bits forced to an exact tie;
- the same exponent range with the kept fraction bits forced to all ones.

Directed words add 65504, 65520, the largest subnormal rounding up, and 2^-25 tying down to zero.

// File: rtl/f2h_pkg.sv
`timescale 1ns/1ps
package f2h_pkg;
  localparam int SP_W      = 32;
  localparam int SP_EXP_W  = 8;
  localparam int SP_MAN_W  = 23;
  localparam int HP_EXP_W  = 5;
  localparam int HP_MAN_W  = 10;
  localparam int HP_W      = 1 + HP_EXP_W + HP_MAN_W;
  localparam int HP_MAG_W  = HP_W - 1;
  localparam int SP_BIAS   = 127;
  localparam int HP_BIAS   = 15;
  localparam int DROP_W    = SP_MAN_W - HP_MAN_W;
  localparam int SIG_W     = SP_MAN_W + 1;
  localparam int NORM_LO   = SP_BIAS - HP_BIAS + 1;
  localparam int NORM_HI   = SP_BIAS + HP_BIAS;

  typedef enum logic [2:0] {
    CL_ZERO, CL_INF, CL_NAN, CL_OVF, CL_NORM, CL_SUB
  } cls_e;
endpackage

// File: rtl/f2h_unpack.sv
`timescale 1ns/1ps
module f2h_unpack
  import f2h_pkg::*;
(
  input  logic [SP_W-1:0]     word,
  output logic                sgn,
  output logic [SP_EXP_W-1:0] ex,
  output logic [SP_MAN_W-1:0] man,
  output cls_e                cls
);
  assign sgn = word[SP_W-1];
  assign ex  = word[SP_W-2 -: SP_EXP_W];
  assign man = word[SP_MAN_W-1:0];

  always_comb begin
    if (ex == '0)
      cls = CL_ZERO;
    else if (ex == '1)
      cls = (man == '0) ? CL_INF : CL_NAN;
    else if (ex > SP_EXP_W'(NORM_HI))
      cls = CL_OVF;
    else if (ex >= SP_EXP_W'(NORM_LO))
      cls = CL_NORM;
    else
      cls = CL_SUB;
  end
endmodule

// File: rtl/f2h_norm_rnd.sv
`timescale 1ns/1ps
module f2h_norm_rnd
  import f2h_pkg::*;
(
  input  logic [SP_EXP_W-1:0] ex,
  input  logic [SP_MAN_W-1:0] man,
  output logic [HP_MAG_W-1:0] mag
);
  logic [HP_MAN_W-1:0] keep;
  logic [HP_EXP_W-1:0] hexp;
  logic                guard, sticky, inc;

  assign keep   = man[SP_MAN_W-1 -: HP_MAN_W];
  assign guard  = man[DROP_W-1];
  assign sticky = |man[DROP_W-2:0];
  assign inc    = guard & (sticky | keep[0]);
  assign hexp   = HP_EXP_W'(ex - SP_EXP_W'(NORM_LO - 1));
  // a fraction carry ripples into the exponent field, up to infinity
  assign mag    = {hexp, keep} + HP_MAG_W'(inc);
endmodule

// File: rtl/f2h_sub_rnd.sv
`timescale 1ns/1ps
module f2h_sub_rnd
  import f2h_pkg::*;
#(
  parameter int SH_CAP = SIG_W + 2
)(
  input  logic [SP_EXP_W-1:0] ex,
  input  logic [SP_MAN_W-1:0] man,
  output logic [HP_MAG_W-1:0] mag
);
  localparam int SHW = $clog2(SH_CAP + 1);
  localparam int VW  = SIG_W + SH_CAP;

  logic [SP_EXP_W-1:0] sh_full;
  logic [SHW-1:0]      sh;
  logic [VW-1:0]       shv;
  logic [SIG_W-1:0]    kept;
  logic                guard, sticky, inc;

  // |x| * 2^24 = sig * 2^(ex-126): right shift by 126-ex
  assign sh_full = SP_EXP_W'(SP_BIAS - 1) - ex;
  assign sh      = (sh_full > SP_EXP_W'(SH_CAP)) ? SHW'(SH_CAP) : SHW'(sh_full);
  assign shv     = {1'b1, man, {SH_CAP{1'b0}}} >> sh;
  assign kept    = shv[VW-1 -: SIG_W];
  assign guard   = shv[SH_CAP-1];
  assign sticky  = |shv[SH_CAP-2:0];
  assign inc     = guard & (sticky | kept[0]);
  assign mag     = HP_MAG_W'(kept) + HP_MAG_W'(inc);
endmodule

// File: rtl/f32_to_f16_conv.sv
`timescale 1ns/1ps
module f32_to_f16_conv
  import f2h_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_vld,
  input  logic [SP_W-1:0] in_f32,
  output logic            out_vld,
  output logic [HP_W-1:0] out_f16
);
  localparam logic [HP_MAG_W-1:0] MAG_INF  = {{HP_EXP_W{1'b1}}, {HP_MAN_W{1'b0}}};
  localparam logic [HP_MAG_W-1:0] MAG_QNAN = {{HP_EXP_W{1'b1}}, 1'b1, {(HP_MAN_W-1){1'b0}}};

  logic                sgn;
  logic [SP_EXP_W-1:0] ex;
  logic [SP_MAN_W-1:0] man;
  cls_e                cls;
  logic [HP_MAG_W-1:0] norm_mag, sub_mag, mag;

  f2h_unpack   u_unpack (.word(in_f32), .sgn(sgn), .ex(ex), .man(man), .cls(cls));
  f2h_norm_rnd u_norm   (.ex(ex), .man(man), .mag(norm_mag));
  f2h_sub_rnd  u_sub    (.ex(ex), .man(man), .mag(sub_mag));

  always_comb begin
    unique case (cls)
      CL_ZERO:        mag = '0;
      CL_INF, CL_OVF: mag = MAG_INF;
      CL_NAN:         mag = MAG_QNAN;
      CL_NORM:        mag = norm_mag;
      default:        mag = sub_mag;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_f16 <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_f16 <= {sgn, mag};
    end
  end
endmodule

// File: rtl/f2h_checker.sv
`timescale 1ns/1ps
module f2h_checker (
  input logic        clk,
  input logic        rst,
  input logic        in_vld,
  input logic [31:0] in_f32,
  input logic        out_vld,
  input logic [15:0] out_f16
);
  AST_RST_CLEARS_VLD: assert property (@(posedge clk) rst |=> !out_vld); // R8
  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld); // R8
  AST_NO_SPURIOUS_VLD: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld); // R8
  AST_ZERO_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_f32[30:23] == 8'h00) |=> out_f16[14:0] == 15'h0000); // R1
  AST_INF_PASS: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_f32[30:23] == 8'hFF && in_f32[22:0] == 23'h0) |=> out_f16[14:0] == 15'h7C00); // R2
  AST_QUIET_NAN: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_f32[30:23] == 8'hFF && in_f32[22:0] != 23'h0) |=> out_f16[14:0] == 15'h7E00); // R3
  AST_OVERFLOW_INF: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_f32[30:23] > 8'd142 && in_f32[30:23] != 8'hFF) |=> out_f16[14:0] == 15'h7C00); // R4
  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_f16[15] == $past(in_f32[31])); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> $stable(out_f16)); // R10
endmodule

bind f32_to_f16_conv f2h_checker i_chk (.*);

// File: tb/test_f32_to_f16_conv.sv
`timescale 1ns/1ps
module test_f32_to_f16_conv;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_vld = 1'b0;
  logic [31:0] in_f32 = '0;
  logic        out_vld;
  logic [15:0] out_f16;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic        exp_vld  = 1'b0;
  logic [15:0] exp_data = '0;
  string       exp_req  = "R8";

  always #2.5 clk = ~clk;

  f32_to_f16_conv i_f32_to_f16_conv (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_f32(in_f32),
    .out_vld(out_vld), .out_f16(out_f16));

  // value in units of 2^-24 is sig*2^(e-126); quantum 2^k units
  function automatic logic [15:0] ref_h(input logic [31:0] w);
    int e = int'(w[30:23]);
    logic s = w[31];
    longint sig, q, r, half, code;
    int k, sh;
    if (e == 0) return {s, 15'h0000};
    if (e == 255) return (w[22:0] == 0) ? {s, 15'h7C00} : {s, 15'h7E00};
    if (e > 142) return {s, 15'h7C00};
    sig = longint'({1'b1, w[22:0]});
    k = (e > 113) ? e - 113 : 0;
    sh = 126 - e + k;
    if (sh >= 40) q = 0;
    else begin
      q = sig >> sh;
      r = sig - (q << sh);
      half = longint'(1) << (sh - 1);
      if (r > half || (r == half && q[0])) q = q + 1;
    end
    code = longint'(k) * 1024 + q;
    if (code >= 64'h7C00) code = 64'h7C00;
    return {s, code[14:0]};
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // checks the previous cycle's result, then drives this cycle
  task automatic step(input logic v, input logic [31:0] w, input string req);
    @(negedge clk);
    chk({exp_req, " valid"}, {15'h0, out_vld}, {15'h0, exp_vld});
    chk(exp_req, out_f16, exp_data);
    in_vld = v;
    in_f32 = w;
    exp_vld = v;
    if (v) begin
      exp_data = ref_h(w);
      exp_req = req;
    end else begin
      exp_req = {req, " hold R10"};
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [7:0]  ee;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset vld", {15'h0, out_vld}, 16'h0000);
    chk("R8 reset data", out_f16, 16'h0000);

    step(1, 32'h00000000, "R1 +zero");
    step(1, 32'h80000000, "R1 -zero R9");
    step(1, 32'h00000001, "R1 denorm");
    step(1, 32'h80400000, "R1 -denorm R9");
    step(1, 32'h7F800000, "R2 +inf");
    step(1, 32'hFF800000, "R2 -inf R9");
    step(1, 32'h7FC00001, "R3 nan");
    step(1, 32'hFF800001, "R3 -nan R9");
    step(1, 32'h7F7FFFFF, "R4 max single");
    step(1, 32'h47800000, "R4 65536");
    step(1, 32'h477FE000, "R5 65504");
    step(1, 32'h3F801000, "R5 tie to even down");
    step(1, 32'h3F803000, "R5 tie to even up");
    step(1, 32'h3F800FFF, "R5 below half");
    step(1, 32'h38800000, "R5 min normal");
    step(1, 32'h477FF000, "R6 65520 to inf");
    step(1, 32'h3F7FF000, "R6 carry to 1.0");
    step(1, 32'h387FF000, "R6 R7 largest subnormal up");
    step(1, 32'h33800000, "R7 min subnormal");
    step(1, 32'h33000000, "R7 tie to zero");
    step(1, 32'h33000001, "R7 above tie");
    step(1, 32'h33C00000, "R7 tie to even 2");
    step(1, 32'h00800000, "R7 tiny normal");
    step(0, 32'h3F800000, "R8");
    step(0, 32'h7F800000, "R8");
    step(1, 32'hC0490FDB, "R5 -pi R9");

    // mid-stream reset clears the output register
    @(negedge clk);
    chk({exp_req, " valid"}, {15'h0, out_vld}, {15'h0, exp_vld});
    chk(exp_req, out_f16, exp_data);
    rst = 1'b1;
    in_vld = 1'b1;
    in_f32 = 32'h3F800000;
    @(negedge clk);
    chk("R8 rst vld", {15'h0, out_vld}, 16'h0000);
    chk("R8 rst data", out_f16, 16'h0000);
    rst = 1'b0;
    in_vld = 1'b0;
    exp_vld = 1'b0;
    exp_data = '0;
    exp_req = "R8 after reset";

    for (int i = 0; i < 4000; i++) begin
      w = $urandom;
      ee = 8'($urandom_range(146, 100));
      case ($urandom_range(3, 0))
        0: ;
        1: w[30:23] = ee;
        2: begin w[30:23] = ee; w[12:0] = 13'h1000; end
        default: begin w[30:23] = ee; w[22:13] = 10'h3FF; end
      endcase
      step(($urandom_range(3, 0) != 0), w, "R5 R6 R7 random");
    end
    step(0, 32'h0, "R10");
    step(0, 32'h0, "R10");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule